// File: doc/BRIEF.md
# Audio Serial Transmit Port

This block takes a stereo pair of 24-bit two's-complement samples over a parallel interface and shifts them out one bit at a time on a serial data line, framed by a bit clock and a word-select (channel) clock. Two framings are offered. In the justified framing the most significant bit leads the half-frame. In the delayed framing, the standard I2S style, the most significant bit starts one bit clock after the word-select edge. Within each half-frame, every bit position past the 24 data bits is sent as zero.

As clock master, the port makes both serial clocks from its own clock. The division ratio comes from a two-bit speed code, and an optional pre-divide halves every rate. As clock slave, it takes the bit clock and the word-select clock from pins and passes them through a synchronizer into its own clock domain, where it finds their edges. The block clock `clk` is the oversampled master clock. It runs at twice the nominal master rate, so the fastest bit clock is `clk`/2. A new sample pair is written into a holding register by a one-cycle valid strobe. It moves into the output stage at the start of a left half-frame, so the two words of a pair always go out together.

Top module: `aud_serial_tx`

## Requirements
- R1: In master mode one "tick" is one `clk` cycle (or every second cycle, see R3). The speed code 00, 01 or 10 gives an SCLK half-period of 4, 2 or 1 ticks. SCLK is low after reset and first rises once that many ticks have passed.
- R2: In master mode LRCK toggles once every 32 SCLK periods (a 32-bit half-frame). It changes only on the `clk` edge where SCLK falls, and it is low after reset.
- R3: When `mdiv_i`=1 in master mode, a tick happens only on every second `clk` edge, starting with the second edge after reset, so every master period doubles. In slave mode `mdiv_i` has no effect.
- R4: Speed code 11 is reserved. One cycle after it is applied, `sclk_o`, `lrck_o` and `sdout_o` are low, and they stay low while the code is held.
- R5: Synchronous active-high `rst` drives `sclk_o`, `lrck_o` and `sdout_o` low. It also restarts the dividers from zero, including when it is applied mid-run.
- R6: Each 24-bit word is sent MSB first. `sdout_o` changes only on the `clk` edge where a bit-clock fall takes effect. In master mode that is the same edge on which SCLK goes low. In slave mode it is the third `clk` edge after the pin falls.
- R7: With `fmt_i2s_i`=0 (justified), the MSB occupies the first SCLK period after an LRCK edge, and the left word is sent while LRCK is high.
- R8: With `fmt_i2s_i`=1 (delayed), the MSB occupies the second SCLK period after an LRCK edge, and the left word is sent while LRCK is low.
- R9: Every half-frame position outside the 24 data bits sends 0. A half-frame shorter than the data drops the trailing bits.
- R10: In slave mode (`master_i`=0), bit and word timing follow `sclk_i` and `lrck_i` through a two-stage synchronizer, and `sclk_o` and `lrck_o` stay low. Half-frames of 16, 32 or 64 SCLK periods are served.
- R11: `pair_valid_i` captures both words together. A captured pair first appears in the next left half-frame that begins after the capture. A right half-frame always carries the right word of the same pair as the left half-frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled master clock (twice the nominal master rate) |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = generate serial clocks, 0 = accept them from pins |
| fmt_i2s_i | input | 1 | 0 = justified framing, 1 = one-bit-delayed framing |
| speed_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| mdiv_i | input | 1 | Master-mode pre-divide by two |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| pair_valid_i | input | 1 | One-cycle strobe that captures left_i and right_i |
| sclk_i | input | 1 | Bit clock pin, used in slave mode |
| lrck_i | input | 1 | Word-select pin, used in slave mode |
| sclk_o | output | 1 | Generated bit clock (low in slave mode) |
| lrck_o | output | 1 | Generated word select (low in slave mode) |
| sdout_o | output | 1 | Serial data |

## Verification
The bench builds the port with its default parameters: 32 bit positions per master half-frame and a two-stage slave synchronizer. With these values, a full master frame lasts at most 1024 cycles, so all three speed codes, with and without the pre-divide, finish within a few frames. The slave bit clock is driven with a four-cycle half-period, which leaves margin over the three-cycle synchronizer latency. Using this setup, the bench runs slave half-frames of 16, 32 and 64 bits, which cover truncation, exact fit and zero padding.

// File: rtl/aport_pkg.sv
package aport_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SBIT_W   = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } pair_t;

    // timing event handed to the framer: a bit-clock fall, whether it opens
    // a new half-frame, and the word-select level after it
    typedef struct packed {
        logic fall;
        logic restart;
        logic lr;
    } tev_t;

    // last value of the tick counter within one bit-clock half-period
    function automatic logic [1:0] half_last(speed_e s);
        case (s)
            SPD_SINGLE: return 2'd3;
            SPD_DOUBLE: return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/aport_mclk_gen.sv
module aport_mclk_gen
    import aport_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       mdiv_i,
    input  logic [1:0] speed_i,
    output logic       sclk_o,
    output logic       lrck_o,
    output tev_t       ev_o
);
    // pos counts bit-clock half-periods over one full frame
    localparam int PW = $clog2(2 * SLOT_W) + 1;

    logic          tgl_q;
    logic [1:0]    hcnt_q;
    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_n;
    logic          tick;
    logic          step;

    always_comb begin
        tick         = mdiv_i ? tgl_q : 1'b1;
        step         = en_i && tick && (hcnt_q == half_last(speed_e'(speed_i)));
        pos_n        = pos_q + PW'(1);
        ev_o.fall    = step && !pos_n[0];
        ev_o.restart = step && (pos_n[PW-2:0] == '0);
        ev_o.lr      = step ? pos_n[PW-1] : pos_q[PW-1];
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            tgl_q  <= 1'b0;
            hcnt_q <= '0;
            pos_q  <= '0;
            sclk_o <= 1'b0;
            lrck_o <= 1'b0;
        end else begin
            tgl_q <= ~tgl_q;
            if (tick) hcnt_q <= step ? 2'd0 : hcnt_q + 2'd1;
            if (step) begin
                pos_q  <= pos_n;
                sclk_o <= pos_n[0];
                lrck_o <= pos_n[PW-1];
            end
        end
    end

    AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (rst || !en_i)
        !$stable(lrck_o) |-> $fell(sclk_o)); // R2

endmodule

// File: rtl/aport_slave_sync.sv
module aport_slave_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             lrck_i,
    output aport_pkg::tev_t  ev_o
);
    logic [SYNC_STAGES:0] sc_q;
    logic [SYNC_STAGES:0] lr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q <= '0;
            lr_q <= '0;
        end else begin
            sc_q <= {sc_q[SYNC_STAGES-1:0], sclk_i};
            lr_q <= {lr_q[SYNC_STAGES-1:0], lrck_i};
        end
    end

    always_comb begin
        ev_o.fall    = sc_q[SYNC_STAGES] && !sc_q[SYNC_STAGES-1];
        ev_o.restart = ev_o.fall && (lr_q[SYNC_STAGES] != lr_q[SYNC_STAGES-1]);
        ev_o.lr      = lr_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/aport_framer.sv
module aport_framer
    import aport_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  idle_i,
    input  logic  fmt_i2s_i,
    input  tev_t  ev_i,
    input  pair_t pair_i,
    input  logic  pair_valid_i,
    output logic  sdout_o
);
    // saturating bit-position counter, wide enough for 64-bit slave halves
    localparam int CNT_W = $clog2(4 * SLOT_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pair_t               hold_q;
    pair_t               act_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_n;
    logic                left_now;
    logic                load;
    logic [SAMPLE_W-1:0] word;
    int                  k;
    int                  idx;
    logic                in_win;
    logic                bit_n;

    always_comb begin
        left_now = ev_i.lr ^ fmt_i2s_i;
        load     = ev_i.fall && ev_i.restart && left_now;
        if (ev_i.restart)        cnt_n = '0;
        else if (cnt_q == CNT_MAX) cnt_n = cnt_q;
        else                     cnt_n = cnt_q + CNT_W'(1);
        k      = int'(cnt_n) - int'(fmt_i2s_i);
        in_win = (k >= 0) && (k < SAMPLE_W);
        idx    = in_win ? (SAMPLE_W - 1 - k) : 0;
        word   = left_now ? (load ? hold_q.l : act_q.l) : act_q.r;
        bit_n  = in_win && word[SBIT_W'(idx)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            act_q   <= '0;
            cnt_q   <= '0;
            sdout_o <= 1'b0;
        end else begin
            if (pair_valid_i) hold_q <= pair_i;
            if (idle_i) begin
                cnt_q   <= '0;
                sdout_o <= 1'b0;
            end else if (ev_i.fall) begin
                cnt_q   <= cnt_n;
                sdout_o <= bit_n;
                if (load) act_q <= hold_q;
            end
        end
    end

    AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdout_o) |-> $past(ev_i.fall || idle_i)); // R6

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ev_i.fall && !in_win) |=> !sdout_o); // R9

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aport_pkg::*;
#(
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                master_i,
    input  logic                fmt_i2s_i,
    input  logic [1:0]          speed_i,
    input  logic                mdiv_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                pair_valid_i,
    input  logic                sclk_i,
    input  logic                lrck_i,
    output logic                sclk_o,
    output logic                lrck_o,
    output logic                sdout_o
);
    logic  idle;
    tev_t  m_ev;
    tev_t  s_ev;
    tev_t  ev;
    pair_t pair;

    assign idle = (speed_e'(speed_i) == SPD_RSVD);
    assign pair = '{l: left_i, r: right_i};
    assign ev   = master_i ? m_ev : s_ev;

    aport_mclk_gen #(.SLOT_W(SLOT_W)) u_mgen (
        .clk     (clk),
        .rst     (rst),
        .en_i    (master_i && !idle),
        .mdiv_i  (mdiv_i),
        .speed_i (speed_i),
        .sclk_o  (sclk_o),
        .lrck_o  (lrck_o),
        .ev_o    (m_ev)
    );

    aport_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ssync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .lrck_i (lrck_i),
        .ev_o   (s_ev)
    );

    aport_framer #(.SLOT_W(SLOT_W)) u_frm (
        .clk          (clk),
        .rst          (rst),
        .idle_i       (idle),
        .fmt_i2s_i    (fmt_i2s_i),
        .ev_i         (ev),
        .pair_i       (pair),
        .pair_valid_i (pair_valid_i),
        .sdout_o      (sdout_o)
    );

    AST_IDLE_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (speed_i == 2'b11) |=> (!sclk_o && !lrck_o && !sdout_o)); // R4

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !master_i |=> (!sclk_o && !lrck_o)); // R10

endmodule

// File: tb/aud_serial_tx_tb.sv
module aud_serial_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master = 1'b1;
    logic        fmt = 1'b0;
    logic [1:0]  speed = 2'b00;
    logic        mdiv = 1'b0;
    logic [23:0] left = '0;
    logic [23:0] right = '0;
    logic        pv = 1'b0;
    logic        sclk_in = 1'b0;
    logic        lrck_in = 1'b0;
    logic        sclk_o, lrck_o, sdout_o;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_tx u_dut (
        .clk(clk), .rst(rst), .master_i(master), .fmt_i2s_i(fmt),
        .speed_i(speed), .mdiv_i(mdiv), .left_i(left), .right_i(right),
        .pair_valid_i(pv), .sclk_i(sclk_in), .lrck_i(lrck_in),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .sdout_o(sdout_o)
    );

    task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- reference clock model (master) ----------------
    int e = 0;
    bit model_on = 0;
    bit slave_chk = 0;
    always @(posedge clk) e <= rst ? 0 : e + 1;

    always @(negedge clk) begin
        if (!rst && model_on) begin
            int ticks, h, p;
            ticks = mdiv ? e / 2 : e;
            h = 4 >> speed;
            p = ticks / h;
            check(sclk_o == p[0], mdiv ? "R3 R1 sclk" : "R1 sclk", sclk_o, p[0]);
            check(lrck_o == p[6], mdiv ? "R3 R2 lrck" : "R2 lrck", lrck_o, p[6]);
        end
        if (!rst && slave_chk)
            check(!sclk_o && !lrck_o, "R10 clock outputs quiet in slave",
                  {sclk_o, lrck_o}, 0);
    end

    // ---------------- slave pin generator ----------------
    bit slv_run = 0;
    int slv_hp = 4;
    int slv_half = 32;
    int hp_cnt = 0;
    int fall_n = 0;
    always @(posedge clk) begin
        #1;
        if (slv_run) begin
            if (hp_cnt == slv_hp - 1) begin
                hp_cnt = 0;
                sclk_in = ~sclk_in;
                if (!sclk_in) begin
                    fall_n++;
                    if (fall_n == slv_half) begin
                        fall_n = 0;
                        lrck_in = ~lrck_in;
                    end
                end
            end else hp_cnt++;
        end
    end

    // ---------------- serial receiver ----------------
    bit          prev_sc = 0;
    bit          rx_started = 0;
    bit          rx_lr = 0;
    int          rx_pos = 0;
    logic [63:0] rx_vec = '0;
    logic [63:0] last_l = '0, last_r = '0;
    int          last_l_n = 0, last_r_n = 0;
    int          l_cnt = 0, r_cnt = 0;

    function automatic bit is_left(bit lr);
        return fmt ? !lr : lr;
    endfunction

    always @(negedge clk) begin
        bit sc, lr;
        sc = master ? sclk_o : sclk_in;
        lr = master ? lrck_o : lrck_in;
        if (rst) begin
            rx_started = 0;
            prev_sc = 0;
        end else begin
            if (!prev_sc && sc) begin
                if (!rx_started || lr != rx_lr) begin
                    if (rx_started) begin
                        if (is_left(rx_lr)) begin
                            last_l = rx_vec; last_l_n = rx_pos; l_cnt++;
                        end else begin
                            last_r = rx_vec; last_r_n = rx_pos; r_cnt++;
                        end
                    end
                    rx_started = 1;
                    rx_lr = lr;
                    rx_pos = 0;
                    rx_vec = '0;
                end
                if (rx_pos < 64) rx_vec[rx_pos] = sdout_o;
                rx_pos++;
            end
            prev_sc = sc;
        end
    end

    function automatic logic [63:0] exp_vec(logic [23:0] w, int n, bit i2s);
        logic [63:0] v;
        v = '0;
        for (int j = 0; j < n && j < 64; j++) begin
            int k;
            k = j - int'(i2s);
            if (k >= 0 && k < 24) v[j] = w[23 - k];
        end
        return v;
    endfunction

    // ---------------- stimulus tasks ----------------
    task automatic do_reset(bit m, bit f, logic [1:0] s, bit d);
        @(posedge clk); #1;
        rst = 1; slv_run = 0; model_on = 0; slave_chk = 0;
        sclk_in = 0; lrck_in = 0; hp_cnt = 0; fall_n = 0;
        master = m; fmt = f; speed = s; mdiv = d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!sclk_o && !lrck_o && !sdout_o, "R5 outputs low in reset",
              {sclk_o, lrck_o, sdout_o}, 0);
        @(posedge clk); #1;
        rst = 0;
    endtask

    task automatic load(logic [23:0] l, logic [23:0] r);
        @(posedge clk); #1;
        left = l; right = r; pv = 1;
        @(posedge clk); #1;
        pv = 0;
    endtask

    task automatic wait_new();
        int l0, r0;
        l0 = l_cnt; r0 = r_cnt;
        while (!(l_cnt >= l0 + 2 && r_cnt >= r0 + 2)) @(negedge clk);
    endtask

    task automatic check_pair(string tag, logic [23:0] l, logic [23:0] r, int n);
        check(last_l == exp_vec(l, n, fmt), {tag, " left half-frame"}, last_l, exp_vec(l, n, fmt));
        check(last_r == exp_vec(r, n, fmt), {tag, " right half-frame"}, last_r, exp_vec(r, n, fmt));
        check(last_l_n == n, {tag, " R2 half-frame length"}, last_l_n, n);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        // R7 R6 R1: master, justified, single speed
        do_reset(1, 0, 2'b00, 0);
        model_on = 1;
        load(24'h9A5C31, 24'h16E7F0);
        wait_new();
        check_pair("R7 R6", 24'h9A5C31, 24'h16E7F0, 32);

        // R8: master, delayed framing, double speed, extreme values
        do_reset(1, 1, 2'b01, 0);
        model_on = 1;
        load(24'h800000, 24'h7FFFFF);
        wait_new();
        check_pair("R8 R9", 24'h800000, 24'h7FFFFF, 32);

        // R3: master, justified, quad speed with pre-divide
        do_reset(1, 0, 2'b10, 1);
        model_on = 1;
        load(24'hFFFFFF, 24'h000001);
        wait_new();
        check_pair("R3 R7", 24'hFFFFFF, 24'h000001, 32);

        // R11: pair coherence, delayed framing, quad speed
        do_reset(1, 1, 2'b10, 0);
        model_on = 1;
        load(24'h123456, 24'hABCDEF);
        wait_new();
        check_pair("R11 first pair", 24'h123456, 24'hABCDEF, 32);
        while (!(rx_started && is_left(rx_lr) && rx_pos >= 8)) @(negedge clk);
        load(24'h5A5A5A, 24'hC3C3C3);
        begin
            int r0;
            r0 = r_cnt;
            while (r_cnt < r0 + 1) @(negedge clk);
        end
        check(last_r == exp_vec(24'hABCDEF, 32, 1), "R11 right stays with its pair",
              last_r, exp_vec(24'hABCDEF, 32, 1));
        wait_new();
        check_pair("R11 second pair", 24'h5A5A5A, 24'hC3C3C3, 32);

        // R5: mid-run reset restarts the dividers (model keeps checking)
        @(posedge clk); #1; rst = 1;
        @(posedge clk); #1; rst = 0;
        repeat (600) @(posedge clk);

        // R4: reserved speed code while running
        do_reset(1, 0, 2'b00, 0);
        model_on = 1;
        load(24'hFFFFFF, 24'hFFFFFF);
        wait_new();
        model_on = 0;
        @(posedge clk); #1; speed = 2'b11;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(!sclk_o && !lrck_o && !sdout_o, "R4 reserved code idles outputs",
                  {sclk_o, lrck_o, sdout_o}, 0);
        end

        // R10 R3: slave, justified, 32-bit halves, pre-divide set (ignored)
        do_reset(0, 0, 2'b00, 1);
        slave_chk = 1; slv_half = 32; slv_run = 1;
        load(24'hC0FFEE, 24'h0BEEF1);
        wait_new();
        check_pair("R10 R3 slave", 24'hC0FFEE, 24'h0BEEF1, 32);

        // R9: slave, delayed framing, 16-bit halves truncate
        do_reset(0, 1, 2'b00, 0);
        slave_chk = 1; slv_half = 16; slv_run = 1;
        load(24'hA1B2C3, 24'h3C2B1A);
        wait_new();
        check_pair("R9 R10 truncation", 24'hA1B2C3, 24'h3C2B1A, 16);

        // R9: slave, justified, 64-bit halves pad with zeros
        do_reset(0, 0, 2'b01, 0);
        slave_chk = 1; slv_half = 64; slv_run = 1;
        load(24'hFEDCBA, 24'h876543);
        wait_new();
        check_pair("R9 R10 padding", 24'hFEDCBA, 24'h876543, 64);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule